// File: doc/BRIEF.md
# Prioritised Masked Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt request lines into a single interrupt output for a processor. A status bit per line follows the line's level. A software-writable mask picks which sources may raise the output. Pending sources are those that are both active and enabled. The output is high whenever any source is pending.

A read-only vector register encodes the lowest-numbered pending source as (index + 1) shifted left by two, so a handler can use it directly as a table offset. The value 0 means that nothing is pending. Register access is 16 bits wide. Reads are combinational on the address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `irq_prio_agg`

## Requirements
- R1: Each status bit copies the level of its input line at every clock edge, so it clears when the line drops. The change is visible in the vector and the output one cycle after the line changes.
- R2: `irq_o` is high exactly when the AND of status and mask is non-zero. It is registered and updates one cycle after an input change.
- R3: A read at offset 0x00 returns ((k + 1) << 2), where k is the lowest-numbered pending source. It returns 0 when no source is pending.
- R4: The mask register at offset 0x02 reads back the value written. A mask write changes `irq_o` on the same clock edge that stores it.
- R5: While reset is asserted, the mask is 0x0010, status is 0 and `irq_o` is low.
- R6: Reads at any offset other than 0x00 and 0x02 return 0. Writes to any offset other than 0x02, including 0x00, leave the mask unchanged.
- R7: Reading the vector has no side effect. Repeated reads return the same value while the inputs are steady.
- R8: An active source whose mask bit is 0 does not raise `irq_o` and does not appear in the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Level-sensitive interrupt request lines |
| wr_en | input | 1 | Write strobe for the register interface |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
A status bit that is stuck or stale shows up in the vector readout one cycle after its line changes, and on `irq_o` on the same edge. A wrong mask value shows in the readback at 0x02 immediately after the write edge, and on `irq_o` on that same edge. A fault in the priority order shows only when two or more sources are pending together, so the stimulus combines the highest and lowest lines and walks each line on its own. Because the output register and the status register are fed by separate paths, any disagreement between them is visible within one cycle.

// File: rtl/irq_prio_agg.sv
module irq_prio_agg #(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_OFS  = 'h0,
  parameter int unsigned MASK_OFS = 'h2,
  parameter int unsigned MASK_RST = 'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);

  localparam int unsigned IDX_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] status_q, mask_q, mask_d, pend;
  logic [IDX_W-1:0] first;
  logic             irq_q;

  wire sel_vec  = addr == ADDR_W'(VEC_OFS);
  wire sel_mask = addr == ADDR_W'(MASK_OFS);
  wire mask_we  = wr_en && sel_mask;

  assign mask_d = mask_we ? wdata[N_SRC-1:0] : mask_q;
  assign pend   = status_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= N_SRC'(MASK_RST);
      irq_q    <= 1'b0;
    end else begin
      status_q <= src_i;
      mask_q   <= mask_d;
      irq_q    <= |(src_i & mask_d);
    end
  end

  always_comb begin
    first = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) first = IDX_W'(i + 1);
  end

  always_comb begin
    rdata = '0;
    if (sel_vec)       rdata = DATA_W'({first, 2'b00});
    else if (sel_mask) rdata = DATA_W'(mask_q);
  end

  assign irq_o = irq_q;

endmodule

module irq_prio_agg_chk #(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_OFS  = 'h0,
  parameter int unsigned MASK_OFS = 'h2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  mask_q
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  wire is_vec  = addr == ADDR_W'(VEC_OFS);
  wire is_mask = addr == ADDR_W'(MASK_OFS);
  wire none    = (status_q & mask_q) == '0;

  p_status_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> status_q == $past(src_i));

  p_irq_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !none);

  p_vec_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_vec && none) |-> rdata == '0);

  p_vec_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_vec && !none) |-> (rdata[1:0] == 2'b00 && rdata != '0 && rdata <= DATA_W'(N_SRC * 4)));

  p_mask_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_mask) |=> mask_q == $past(wdata[N_SRC-1:0]));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_mask) |=> $stable(mask_q));

  p_other_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_vec && !is_mask) |-> rdata == '0);

endmodule

bind irq_prio_agg irq_prio_agg_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .VEC_OFS(VEC_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/tb_irq_prio_agg.sv
`timescale 1ns/1ps
module tb_irq_prio_agg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  irq_prio_agg dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  typedef struct {
    logic [15:0] rd;
    logic        irq;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [15:0] m_mask = 16'h0010;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [15:0] p);
    for (int i = 0; i < 16; i++)
      if (p[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  task automatic cyc(input logic [15:0] lines, input bit wr, input logic [11:0] a,
                     input logic [15:0] wd, input string tag);
    item_t it;
    logic [15:0] p;
    @(negedge clk);
    src_i = lines; wr_en = wr; addr = a; wdata = wd;
    if (wr && a == 12'h002) m_mask = wd;
    p = lines & m_mask;
    it.irq = |p;
    it.rd  = (a == 12'h000) ? vec_of(p) : (a == 12'h002) ? m_mask : 16'h0;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(rdata === it.rd, {it.tag, " rdata"}, rdata, it.rd);
      chk(irq_o === it.irq, {it.tag, " irq"}, {15'h0, irq_o}, {15'h0, it.irq});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    src_i = 16'hFFEF;
    #21;
    addr = 12'h000; #1;
    chk(rdata === 16'h0000, "R5 reset vector", rdata, 16'h0000);
    chk(irq_o === 1'b0, "R5 reset irq", {15'h0, irq_o}, 16'h0);
    addr = 12'h002; #1;
    chk(rdata === 16'h0010, "R5 reset mask", rdata, 16'h0010);
    src_i = '0;
    @(negedge clk); rst_n = 1'b1;

    cyc(16'h0000, 0, 12'h000, 0, "R3 idle");
    cyc(16'h0010, 0, 12'h000, 0, "R1 R2 R3 line4");
    cyc(16'h0008, 0, 12'h000, 0, "R8 masked line3");
    cyc(16'h0008, 1, 12'h002, 16'hFFFF, "R4 unmask");
    cyc(16'h0008, 0, 12'h000, 0, "R3 line3");
    cyc(16'h8000, 0, 12'h000, 0, "R3 line15");
    cyc(16'h8001, 0, 12'h000, 0, "R3 lowest wins");
    cyc(16'h0000, 0, 12'h000, 0, "R1 lines drop");
    cyc(16'h0A00, 0, 12'h000, 0, "R7 read1");
    cyc(16'h0A00, 0, 12'h000, 0, "R7 read2");
    cyc(16'h0A00, 0, 12'h000, 0, "R7 read3");
    cyc(16'h0A00, 1, 12'h000, 16'h0000, "R6 write vec off");
    cyc(16'h0A00, 1, 12'h004, 16'h0000, "R6 write 0x04");
    cyc(16'h0A00, 0, 12'h002, 0, "R6 mask kept");
    cyc(16'h0A00, 0, 12'h004, 0, "R6 read 0x04");
    cyc(16'h0A00, 0, 12'h001, 0, "R6 read 0x01");
    cyc(16'h0A00, 0, 12'h010, 0, "R6 read 0x10");
    cyc(16'hFFFF, 1, 12'h002, 16'h0000, "R8 all masked");
    cyc(16'hFFFF, 0, 12'h000, 0, "R8 vec none");
    cyc(16'hFFFF, 1, 12'h002, 16'h4400, "R4 partial mask");
    cyc(16'hFFFF, 0, 12'h000, 0, "R3 partial mask vec");
    cyc(16'h0400, 1, 12'h002, 16'hFFFF, "R4 mask all");
    for (int k = 0; k < 16; k++)
      cyc(16'(1 << k), 0, 12'h000, 0, $sformatf("R3 walk %0d", k));
    cyc(16'h0000, 0, 12'h000, 0, "R2 final idle");
    @(negedge clk); wr_en = 0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule